// File: doc/BRIEF.md
# Partitioned Sub-Word Add/Subtract Unit

This block is a 64-bit integer add/subtract unit that treats each operand as a short vector of narrow lanes. For each operation the caller picks the lane width: eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. Every lane performs the same addition or subtraction in the same cycle. The carry path is cut at each active lane edge, so no lane affects its neighbour.

Each lane either wraps modulo its width or saturates. Saturation can be signed, clamping to the lane's largest or smallest two's-complement value, or unsigned, clamping to all-ones on overflow and to zero on underflow. The unit holds no programmer-visible state and signals no error conditions. A result word and a clamp mask come out of one register stage, one cycle after the input strobe. The clamp mask has one bit per byte slice.

Top module: `simd_lane_alu`

## Requirements
- R1: A cycle with `in_valid` high makes `out_valid` high on the next cycle, with `result` and `sat_flags` for that operation. After a cycle with `in_valid` low, `out_valid` is low and `result` and `sat_flags` keep their previous values.
- R2: `lane_sel` encodes the lane width: 0 selects 8-bit lanes, 1 selects 16-bit lanes, 2 selects 32-bit lanes, and 3 behaves exactly like 2.
- R3: With `sat_en` low and `op_sub` low, each lane of `result` is (a + b) mod 2^w for lane width w. No carry passes between lanes. `sat_flags` is all zero, and `sat_signed` has no effect.
- R4: With `op_sub` high, each lane computes a − b. In wrap mode this is taken modulo 2^w.
- R5: With `sat_en` and `sat_signed` high, a lane whose true signed result exceeds 2^(w−1)−1 yields 2^(w−1)−1. A lane whose true signed result is below −2^(w−1) yields −2^(w−1).
- R6: With `sat_en` high and `sat_signed` low, the operands are unsigned. An add that exceeds 2^w−1 yields all-ones, and a subtract below zero yields zero.
- R7: `sat_flags` bit k covers result bits [8k+7:8k]. It is set exactly when the lane containing that byte was clamped, so every byte of one lane carries the same flag.
- R8: While `rst` is high at a clock edge, the registers clear: `out_valid` goes low and `result` and `sat_flags` go to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op_a | input | 64 | First operand vector |
| op_b | input | 64 | Second operand vector |
| lane_sel | input | 2 | Lane width: 0 = 8, 1 = 16, 2 or 3 = 32 bits |
| op_sub | input | 1 | 0 = add, 1 = subtract (a − b) |
| sat_en | input | 1 | 1 = saturate, 0 = wrap |
| sat_signed | input | 1 | Saturation kind: 1 = signed, 0 = unsigned |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Lane-wise result |
| sat_flags | output | 8 | Per-byte clamp flags |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid relation and result holding;
- the clear state after reset;
- all-zero flags in wrap mode;
- equal flags across the bytes of a 16-bit or 32-bit lane;
- legal clamp values in clamped 8-bit lanes.

The lane arithmetic itself can only be shown by the bench's scenarios. These compare every result against an independent per-lane model, using directed edge operands and random operands. That arithmetic covers:
- carry isolation at lane edges;
- correct subtraction;
- exact clamp points in each width;
- the aliasing of `lane_sel` value 3.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  typedef enum logic [1:0] {
    LANE_B8  = 2'd0,
    LANE_B16 = 2'd1,
    LANE_B32 = 2'd2,
    LANE_ALT = 2'd3
  } lane_e;

  // log2 of the number of byte slices per lane
  function automatic int lane_log2(input logic [1:0] sel);
    case (lane_e'(sel))
      LANE_B8:  return 0;
      LANE_B16: return 1;
      default:  return 2;
    endcase
  endfunction
endpackage

// File: rtl/simd_slice_add.sv
module simd_slice_add #(
  parameter int SLICE_W = 8
) (
  input  logic [SLICE_W-1:0] a,
  input  logic [SLICE_W-1:0] b,
  input  logic               cin,
  output logic [SLICE_W-1:0] sum,
  output logic               cout,
  output logic               sovf
);
  logic [SLICE_W:0] full;

  always_comb begin
    full = {1'b0, a} + {1'b0, b} + {{SLICE_W{1'b0}}, cin};
    sum  = full[SLICE_W-1:0];
    cout = full[SLICE_W];
    sovf = (a[SLICE_W-1] == b[SLICE_W-1]) && (sum[SLICE_W-1] != a[SLICE_W-1]);
  end
endmodule

// File: rtl/simd_slice_sat.sv
module simd_slice_sat #(
  parameter int SLICE_W = 8
) (
  input  logic [SLICE_W-1:0] sum,
  input  logic               sat_en,
  input  logic               sat_signed,
  input  logic               op_sub,
  input  logic               is_top,
  input  logic               lane_cout,
  input  logic               lane_sovf,
  input  logic               lane_amsb,
  output logic [SLICE_W-1:0] dout,
  output logic               clamped
);
  localparam logic [SLICE_W-1:0] ONES = '1;
  localparam logic [SLICE_W-1:0] ZERO = '0;
  localparam logic [SLICE_W-1:0] SMAX = {1'b0, {(SLICE_W-1){1'b1}}};
  localparam logic [SLICE_W-1:0] SMIN = {1'b1, {(SLICE_W-1){1'b0}}};

  logic u_over, u_under, s_hit;

  always_comb begin
    u_over  = !op_sub && lane_cout;
    u_under = op_sub && !lane_cout;
    s_hit   = lane_sovf;
    clamped = 1'b0;
    dout    = sum;
    if (sat_en) begin
      if (sat_signed) begin
        if (s_hit) begin
          clamped = 1'b1;
          if (!lane_amsb) dout = is_top ? SMAX : ONES;
          else            dout = is_top ? SMIN : ZERO;
        end
      end else if (u_over) begin
        clamped = 1'b1;
        dout    = ONES;
      end else if (u_under) begin
        clamped = 1'b1;
        dout    = ZERO;
      end
    end
  end
endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu #(
  parameter int DATA_W  = 64,
  parameter int SLICE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [DATA_W-1:0]          op_a,
  input  logic [DATA_W-1:0]          op_b,
  input  logic [1:0]                 lane_sel,
  input  logic                       op_sub,
  input  logic                       sat_en,
  input  logic                       sat_signed,
  output logic                       out_valid,
  output logic [DATA_W-1:0]          result,
  output logic [DATA_W/SLICE_W-1:0]  sat_flags
);
  import simd_alu_pkg::*;

  localparam int NSLICE = DATA_W / SLICE_W;

  logic [DATA_W-1:0] b_eff;
  logic [NSLICE-1:0] seg_start, seg_top;
  logic [NSLICE-1:0] carry_in, carry_out, s_ovf, a_msb;
  logic [NSLICE-1:0] lane_cout, lane_sovf, lane_amsb;
  logic [NSLICE-1:0] clamp_c;
  logic [DATA_W-1:0] sum_c, res_c;
  int                span_mask;

  assign b_eff = op_sub ? ~op_b : op_b;

  // lane edge detection and lane-top broadcast
  always_comb begin
    span_mask = (1 << lane_log2(lane_sel)) - 1;
    for (int i = 0; i < NSLICE; i++) begin
      seg_start[i] = ((i & span_mask) == 0);
      seg_top[i]   = ((i & span_mask) == span_mask);
    end
    for (int j = 0; j < NSLICE; j++) begin
      lane_cout[j] = carry_out[j | span_mask];
      lane_sovf[j] = s_ovf[j | span_mask];
      lane_amsb[j] = a_msb[j | span_mask];
    end
  end

  for (genvar g = 0; g < NSLICE; g++) begin : g_slice
    if (g == 0) begin : g_first
      assign carry_in[g] = op_sub;
    end else begin : g_rest
      assign carry_in[g] = seg_start[g] ? op_sub : carry_out[g-1];
    end

    assign a_msb[g] = op_a[g*SLICE_W + SLICE_W - 1];

    simd_slice_add #(.SLICE_W(SLICE_W)) u_add (
      .a    (op_a[g*SLICE_W +: SLICE_W]),
      .b    (b_eff[g*SLICE_W +: SLICE_W]),
      .cin  (carry_in[g]),
      .sum  (sum_c[g*SLICE_W +: SLICE_W]),
      .cout (carry_out[g]),
      .sovf (s_ovf[g])
    );

    simd_slice_sat #(.SLICE_W(SLICE_W)) u_sat (
      .sum        (sum_c[g*SLICE_W +: SLICE_W]),
      .sat_en     (sat_en),
      .sat_signed (sat_signed),
      .op_sub     (op_sub),
      .is_top     (seg_top[g]),
      .lane_cout  (lane_cout[g]),
      .lane_sovf  (lane_sovf[g]),
      .lane_amsb  (lane_amsb[g]),
      .dout       (res_c[g*SLICE_W +: SLICE_W]),
      .clamped    (clamp_c[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      sat_flags <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= res_c;
        sat_flags <= clamp_c;
      end
    end
  end
endmodule

// File: rtl/simd_lane_alu_chk.sv
module simd_lane_alu_chk #(
  parameter int DATA_W  = 64,
  parameter int SLICE_W = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      in_valid,
  input logic [1:0]                lane_sel,
  input logic                      op_sub,
  input logic                      sat_en,
  input logic                      sat_signed,
  input logic                      out_valid,
  input logic [DATA_W-1:0]         result,
  input logic [DATA_W/SLICE_W-1:0] sat_flags
);
  localparam int NSLICE = DATA_W / SLICE_W;
  localparam logic [SLICE_W-1:0] SMAX = {1'b0, {(SLICE_W-1){1'b1}}};
  localparam logic [SLICE_W-1:0] SMIN = {1'b1, {(SLICE_W-1){1'b0}}};

  assert_valid_follow_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result) && $stable(sat_flags)));

  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0 && sat_flags == '0));

  assert_wrap_noflag_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !sat_en) |=> sat_flags == '0);

  for (genvar k = 0; k < NSLICE; k++) begin : g_chk
    localparam int P16 = k ^ 1;
    localparam int P32 = k ^ 3;

    assert_flag_pair_R7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && lane_sel == 2'd1) |=> sat_flags[k] == sat_flags[P16]);

    assert_flag_quad_R7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && lane_sel[1]) |=> sat_flags[k] == sat_flags[P32]);

    assert_uadd_clamp_R6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && lane_sel == 2'd0 && sat_en && !sat_signed && !op_sub)
        |=> (!sat_flags[k] || result[k*SLICE_W +: SLICE_W] == '1));

    assert_usub_clamp_R6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && lane_sel == 2'd0 && sat_en && !sat_signed && op_sub)
        |=> (!sat_flags[k] || result[k*SLICE_W +: SLICE_W] == '0));

    assert_sclamp_R5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && lane_sel == 2'd0 && sat_en && sat_signed)
        |=> (!sat_flags[k] || result[k*SLICE_W +: SLICE_W] == SMAX
             || result[k*SLICE_W +: SLICE_W] == SMIN));
  end
endmodule

bind simd_lane_alu simd_lane_alu_chk #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .lane_sel   (lane_sel),
  .op_sub     (op_sub),
  .sat_en     (sat_en),
  .sat_signed (sat_signed),
  .out_valid  (out_valid),
  .result     (result),
  .sat_flags  (sat_flags)
);

// File: tb/sim_simd_lane_alu.sv
module sim_simd_lane_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [1:0]  lane_sel = '0;
  logic        op_sub = 1'b0, sat_en = 1'b0, sat_signed = 1'b0;
  logic        out_valid;
  logic [63:0] result;
  logic [7:0]  sat_flags;

  int checks = 0;
  int errors = 0;
  logic [63:0] last_res;
  logic [7:0]  last_flg;

  always #10 clk = ~clk;

  simd_lane_alu #(.DATA_W(64), .SLICE_W(8)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .lane_sel(lane_sel), .op_sub(op_sub), .sat_en(sat_en), .sat_signed(sat_signed),
    .out_valid(out_valid), .result(result), .sat_flags(sat_flags)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void ref_op(input logic [63:0] a, input logic [63:0] b,
                                 input logic [1:0] ls, input logic sub,
                                 input logic sat, input logic sg,
                                 output logic [63:0] r, output logic [7:0] f);
    int w;
    longint msk, ua, ub, val, hi, lo;
    w   = (ls == 2'd0) ? 8 : (ls == 2'd1) ? 16 : 32;
    msk = (longint'(1) << w) - 1;
    r = '0;
    f = '0;
    for (int k = 0; k < 64 / w; k++) begin
      ua = longint'(a >> (k * w)) & msk;
      ub = longint'(b >> (k * w)) & msk;
      if (sg) begin
        if (ua[w-1]) ua = ua - (longint'(1) << w);
        if (ub[w-1]) ub = ub - (longint'(1) << w);
        hi = (longint'(1) << (w - 1)) - 1;
        lo = -(longint'(1) << (w - 1));
      end else begin
        hi = msk;
        lo = 0;
      end
      val = sub ? ua - ub : ua + ub;
      if (sat && (val > hi || val < lo)) begin
        val = (val > hi) ? hi : lo;
        f = f | (8'(((1 << (w / 8)) - 1)) << (k * w / 8));
      end
      r = r | (64'(val & msk) << (k * w));
    end
  endfunction

  task automatic run(input logic [63:0] a, input logic [63:0] b, input logic [1:0] ls,
                     input logic sub, input logic sat, input logic sg, input string tag);
    logic [63:0] er;
    logic [7:0]  ef;
    @(negedge clk);
    op_a = a; op_b = b; lane_sel = ls; op_sub = sub; sat_en = sat; sat_signed = sg;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    ref_op(a, b, ls, sub, sat, sg, er, ef);
    check("R1 out_valid", 64'(out_valid), 64'd1);
    check(tag, result, er);
    check("R7 flags", 64'(sat_flags), 64'(ef));
    last_res = er;
    last_flg = ef;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8 reset state
    check("R8 out_valid", 64'(out_valid), 64'd0);
    check("R8 result", result, 64'd0);
    check("R8 flags", 64'(sat_flags), 64'd0);

    // R3 carry isolation at byte, halfword and word edges
    run(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 2'd0, 0, 0, 0, "R3 wrap8");
    run(64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 2'd1, 0, 0, 1, "R3 wrap16");
    run(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 2'd2, 0, 0, 0, "R3 wrap32");
    // R4 wrap subtract
    run(64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101, 2'd0, 1, 0, 0, "R4 sub8");
    // R6 unsigned saturation
    run(64'hFF80_0001_FFFF_0000, 64'h0180_FFFF_0001_0000, 2'd0, 0, 1, 0, "R6 uadd8");
    run(64'h0000_0005_0010_8000, 64'h0001_0004_0020_8001, 2'd1, 1, 1, 0, "R6 usub16");
    // R5 signed saturation
    run(64'h7F80_7F80_0102_0304, 64'h0101_FF81_0101_0101, 2'd0, 0, 1, 1, "R5 sadd8");
    run(64'h8000_0000_7FFF_FFFF, 64'h0000_0001_FFFF_FFFF, 2'd2, 1, 1, 1, "R5 ssub32");
    run(64'h7FFF_8000_1234_7FFF, 64'h0001_0001_1111_8000, 2'd1, 0, 1, 1, "R5 sadd16");
    // R2 lane_sel 3 aliases to 32-bit lanes
    run(64'hFFFF_FFFF_7FFF_FFFF, 64'h0000_0001_0000_0001, 2'd3, 0, 1, 1, "R2 alias");
    // R1 hold with idle strobe and changing inputs
    @(negedge clk);
    op_a = 64'h1234_5678_9ABC_DEF0;
    check("R1 idle valid", 64'(out_valid), 64'd0);
    check("R1 hold result", result, last_res);
    check("R1 hold flags", 64'(sat_flags), 64'(last_flg));

    for (int n = 0; n < 400; n++) begin
      logic [63:0] a, b;
      logic [1:0]  ls;
      logic        sub, sat, sg;
      string       tag;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (($urandom % 4) == 0) a = a | 64'h7F7F_7F7F_7F7F_7F7F;
      if (($urandom % 4) == 0) b = b & 64'h8080_8080_8080_8080;
      ls  = 2'($urandom % 4);
      sub = 1'($urandom);
      sat = 1'($urandom);
      sg  = 1'($urandom);
      tag = !sat ? (sub ? "R4 rand" : "R3 rand") : (sg ? "R5 rand" : "R6 rand");
      run(a, b, ls, sub, sat, sg, tag);
    end

    // R8 reset mid-stream
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R8 reclear", result, 64'd0);
    check("R8 reclear flags", 64'(sat_flags), 64'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule